// File: doc/BRIEF.md
# Buffered-Compare Interval Timer

This block is a 16-bit up-counter that produces a fixed-period compare-match pulse and a square-wave output level. The counter advances on a count tick. The tick is either a single-cycle enable from an internal power-of-two prescaler of the system clock, or the rising edge of an external event input after it passes a synchronizer. There are no derived clocks anywhere in the block.

Software sets the count enable, the tick source, the prescale select, the mode and a 16-bit compare value. While the block is stopped, the counter rests at FFFFH. The first count tick after enabling rolls it to 0000H, inverts the output and loads the compare value into a private buffer. From then on the counter runs up to the buffered value and clears on the following tick. That clearing tick inverts the output and raises the match pulse. A new compare value written during counting waits in the register until the next match, so a period that is in progress is never cut short.

Top module: `ivl_timer`

## Requirements
- R1: After reset, `count_o` reads FFFFH and both `tmr_out` and `irq_match` are 0.
- R2: When the timer is enabled, the counter stays at FFFFH until the first count tick after the enable. On that tick it becomes 0000H and `tmr_out` inverts, from 0 to 1. That start tick raises no match pulse.
- R3: At the start tick, `cmp_val` is copied into the compare buffer. When the counter equals the buffer, the next count tick clears the counter to 0000H, inverts `tmr_out` and sets `irq_match` for the cycle after that tick.
- R4: With compare value C, consecutive `irq_match` pulses are (C+1) count ticks apart. Any tick that does not match adds 1 to the counter.
- R5: With `ext_sel`=0, the count tick comes from a 7-bit prescale counter that runs freely from reset. The tick is active in every cycle in which the low `clk_sel` bits of that counter are all ones. This gives one tick every 2^`clk_sel` system cycles (1 to 128), and no count change happens between ticks.
- R6: With `ext_sel`=1, the count tick is the rising edge of `ev_in` after two synchronizing flip-flops. Each 0-to-1 change of `ev_in` moves the counter exactly once, on the third clock edge after the change is sampled. A falling edge moves nothing.
- R7: Clearing `cnt_en` stops the timer. From the next clock edge, `count_o` is FFFFH, `tmr_out` is 0 and `irq_match` is 0. Enabling again restarts the timer as in R2.
- R8: Only `mode_sel`=000 (interval mode) counts. Any other value keeps the block in its stopped state, as in R7, even with `cnt_en`=1.
- R9: A new `cmp_val` written while the timer is counting does not change the period in progress. It is loaded into the buffer at the next match and sets the length of the period after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Count enable |
| clk_sel | input | 3 | Prescale select, tick every 2^clk_sel cycles |
| mode_sel | input | 3 | Mode field, 000 = interval |
| ext_sel | input | 1 | 1 = count rising edges of ev_in |
| cmp_val | input | 16 | Compare register value |
| ev_in | input | 1 | External event input, asynchronous |
| irq_match | output | 1 | Compare-match pulse |
| tmr_out | output | 1 | Timer output level |
| count_o | output | 16 | Current counter value |

## Verification
The main function is tried with several compare values at divide-by-1 and divide-by-4, and with the slowest divide-by-128. These runs separate a period of C ticks from one of C+1, and a tick taken every cycle from a prescaled tick. A compare write in the middle of a period shows whether the buffer loads at once or at the next match, because the two cases give periods of different lengths. Pulse trains on the event input, with the internal prescaler also running, show whether the counter follows the synchronized edges or the internal clock. Trains with different widths and gaps show whether falling edges are ignored. Enabling at different prescaler phases shows whether the start waits for a tick or follows the enable write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    parameter int unsigned TMR_W = 16;

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
        logic [TMR_W-1:0] cmp_buf;
        logic             run;
        logic             tog;
        logic             irq;
    } core_st_t;

    localparam logic [TMR_W-1:0] IDLE_CNT = {TMR_W{1'b1}};
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int unsigned NDIV  = 2 ** SEL_W;
    localparam int unsigned DIV_W = NDIV - 1;

    logic [DIV_W-1:0] div_d, div_q;
    logic [NDIV-1:0]  tick_vec;

    // one comparator per divide ratio, picked by sel
    for (genvar i = 0; i < NDIV; i++) begin : g_ratio
        localparam logic [DIV_W-1:0] MASK = DIV_W'((1 << i) - 1);
        assign tick_vec[i] = ((div_q & MASK) == MASK);
    end

    always_comb begin
        div_d = div_q + 1'b1;
        tick  = tick_vec[sel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // divide-by-1 ticks every cycle
    assert_div1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |-> tick);
    // any ratio of two or more cannot tick in two cycles in a row
    assert_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel != '0 && $stable(sel)) |=> !tick);
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_in,
    output logic rise
);
    logic [SYNC_STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SYNC_STAGES-1:0], ev_in};
        rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assert_single_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act,
    input  logic             tick,
    input  logic [TMR_W-1:0] cmp_val,
    output logic [TMR_W-1:0] cnt,
    output logic             tog,
    output logic             irq
);
    core_st_t st_d, st_q;
    logic     hit;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        hit      = (st_q.cnt == st_q.cmp_buf);
        if (!act) begin
            st_d.cnt = IDLE_CNT;
            st_d.run = 1'b0;
            st_d.tog = 1'b0;
        end else if (tick) begin
            if (!st_q.run) begin
                st_d.cnt     = '0;
                st_d.run     = 1'b1;
                st_d.tog     = ~st_q.tog;
                st_d.cmp_buf = cmp_val;
            end else if (hit) begin
                st_d.cnt     = '0;
                st_d.tog     = ~st_q.tog;
                st_d.irq     = 1'b1;
                st_d.cmp_buf = cmp_val;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt     <= IDLE_CNT;
            st_q.cmp_buf <= '0;
            st_q.run     <= 1'b0;
            st_q.tog     <= 1'b0;
            st_q.irq     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign tog = st_q.tog;
    assign irq = st_q.irq;

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.run) |-> (st_q.cnt == '0 && st_q.tog && !st_q.irq));
    assert_match_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> (st_q.cnt == '0 && st_q.tog != $past(st_q.tog)));
    assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (act && tick && st_q.run && !hit) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !tick) |=> $stable(st_q.cnt));
    assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> (st_q.cnt == IDLE_CNT && !st_q.tog && !st_q.irq));
    assert_buf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && $past(st_q.run) && !st_q.irq) |-> $stable(st_q.cmp_buf));
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
    import tmr_pkg::*;
#(
    parameter int unsigned SEL_W       = 3,
    parameter int unsigned MODE_W      = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              ext_sel,
    input  logic [TMR_W-1:0]  cmp_val,
    input  logic              ev_in,
    output logic              irq_match,
    output logic              tmr_out,
    output logic [TMR_W-1:0]  count_o
);
    localparam logic [MODE_W-1:0] MODE_INTERVAL = '0;

    logic int_tick, ev_rise, cnt_tick, act;

    tmr_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .sel  (clk_sel),
        .tick (int_tick)
    );

    tmr_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .ev_in(ev_in),
        .rise (ev_rise)
    );

    always_comb begin
        act      = cnt_en && (mode_sel == MODE_INTERVAL);
        cnt_tick = ext_sel ? ev_rise : int_tick;
    end

    tmr_core u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .act    (act),
        .tick   (cnt_tick),
        .cmp_val(cmp_val),
        .cnt    (count_o),
        .tog    (tmr_out),
        .irq    (irq_match)
    );

    assert_mode_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel != MODE_INTERVAL) |=> (count_o == IDLE_CNT && !tmr_out));
endmodule

// File: tb/sim_ivl_timer.sv
module sim_ivl_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic [2:0]  clk_sel = 3'd0;
    logic [2:0]  mode_sel = 3'd0;
    logic        ext_sel = 1'b0;
    logic [15:0] cmp_val = 16'd0;
    logic        ev_in = 1'b0;
    logic        irq_match, tmr_out;
    logic [15:0] count_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit cmp_on = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    ivl_timer u0 (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .clk_sel(clk_sel),
        .mode_sel(mode_sel), .ext_sel(ext_sel), .cmp_val(cmp_val),
        .ev_in(ev_in), .irq_match(irq_match), .tmr_out(tmr_out),
        .count_o(count_o)
    );

    // behavioural reference, stepped once per clock
    int          m_pre;
    bit          m_e1, m_e2, m_e3;
    int          m_cnt, m_buf;
    bit          m_run, m_out, m_irq;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre = 0; m_e1 = 0; m_e2 = 0; m_e3 = 0;
            m_cnt = 65535; m_buf = 0; m_run = 0; m_out = 0; m_irq = 0;
        end else begin
            int  period;
            bit  tk;
            period = 1 << clk_sel;
            tk = ext_sel ? (m_e2 && !m_e3) : ((m_pre % period) == period - 1);
            m_pre++;
            m_e3 = m_e2; m_e2 = m_e1; m_e1 = ev_in;
            m_irq = 0;
            if (!cnt_en || mode_sel != 3'd0) begin
                m_cnt = 65535; m_run = 0; m_out = 0;
            end else if (tk) begin
                if (!m_run) begin
                    m_run = 1; m_cnt = 0; m_out = !m_out; m_buf = cmp_val;
                end else if (m_cnt == m_buf) begin
                    m_cnt = 0; m_out = !m_out; m_irq = 1; m_buf = cmp_val;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
        end
    end

    task automatic chk(bit ok, string req, int act_v, int exp_v, string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act_v, exp_v);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk(count_o == m_cnt[15:0], cur_req, count_o, m_cnt, "count vs model");
            chk(tmr_out == m_out, cur_req, tmr_out, m_out, "output vs model");
            chk(irq_match == m_irq, cur_req, irq_match, m_irq, "irq vs model");
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic gap(output int n);
        @(negedge clk);
        while (!irq_match) @(negedge clk);
        n = 0;
        do begin @(negedge clk); n++; end while (!irq_match);
    endtask

    task automatic pulse(int hi, int lo);
        ev_in = 1'b1; cyc(hi);
        ev_in = 1'b0; cyc(lo);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        int n;
        cyc(3);
        // R1 reset state
        chk(count_o == 16'hFFFF, "R1", count_o, 16'hFFFF, "reset count");
        chk(tmr_out == 0, "R1", tmr_out, 0, "reset output");
        chk(irq_match == 0, "R1", irq_match, 0, "reset irq");
        rst_n = 1'b1;
        cmp_on = 1;
        cyc(2);

        // R2 start waits for a prescaled tick
        cur_req = "R2";
        clk_sel = 3'd3; cmp_val = 16'd4;
        cyc(3);
        cnt_en = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (count_o == 16'hFFFF && n < 20);
        chk(count_o == 0, "R2", count_o, 0, "count after start tick");
        chk(tmr_out == 1, "R2", tmr_out, 1, "output after start tick");
        chk(irq_match == 0, "R2", irq_match, 0, "no irq at start");
        chk(n >= 1 && n <= 8, "R2", n, 8, "start within one prescale period");

        // R3/R4 divide-by-1, several compare values
        cur_req = "R4";
        cnt_en = 0; cyc(2);
        clk_sel = 3'd0; cmp_val = 16'd3; cnt_en = 1;
        gap(n); chk(n == 4, "R4", n, 4, "period C=3 div1");
        gap(n); chk(n == 4, "R3", n, 4, "repeat period C=3");
        cnt_en = 0; cyc(2);
        cmp_val = 16'd0; cnt_en = 1;
        cyc(4);
        gap(n); chk(n == 1, "R4", n, 1, "period C=0 div1");
        cnt_en = 0; cyc(2);
        cmp_val = 16'd10; cnt_en = 1;
        gap(n); chk(n == 11, "R4", n, 11, "period C=10 div1");

        // R5 divide-by-4
        cur_req = "R5";
        cnt_en = 0; cyc(2);
        clk_sel = 3'd2; cmp_val = 16'd5; cnt_en = 1;
        gap(n); chk(n == 24, "R5", n, 24, "period C=5 div4");

        // R9 compare write mid-period
        cur_req = "R9";
        @(negedge clk); while (!irq_match) @(negedge clk);
        n = 0;
        repeat (3) begin @(negedge clk); n++; end
        cmp_val = 16'd9;
        while (!irq_match) begin @(negedge clk); n++; end
        chk(n == 24, "R9", n, 24, "period in progress keeps old value");
        n = 0;
        do begin @(negedge clk); n++; end while (!irq_match);
        chk(n == 40, "R9", n, 40, "next period uses new value");

        // R7 stop
        cur_req = "R7";
        cnt_en = 0;
        @(negedge clk);
        chk(count_o == 16'hFFFF, "R7", count_o, 16'hFFFF, "count after stop");
        chk(tmr_out == 0, "R7", tmr_out, 0, "output after stop");
        cyc(10);
        chk(irq_match == 0 && count_o == 16'hFFFF, "R7", count_o, 16'hFFFF, "held while stopped");

        // R8 non-interval mode stays stopped
        cur_req = "R8";
        mode_sel = 3'b010; cnt_en = 1; clk_sel = 3'd0;
        cyc(20);
        chk(count_o == 16'hFFFF, "R8", count_o, 16'hFFFF, "mode 010 count");
        chk(tmr_out == 0, "R8", tmr_out, 0, "mode 010 output");
        cnt_en = 0; mode_sel = 3'd0; cyc(2);

        // R6 external events, prescaler running underneath
        cur_req = "R6";
        ext_sel = 1; clk_sel = 3'd0; cmp_val = 16'd2; cnt_en = 1;
        cyc(5);
        chk(count_o == 16'hFFFF, "R6", count_o, 16'hFFFF, "no count without events");
        pulse(2, 3);
        pulse(4, 2);
        cyc(2);
        chk(count_o == 1, "R6", count_o, 1, "two rising edges");
        ev_in = 1; cyc(6);
        chk(count_o == 2, "R6", count_o, 2, "long high counts once");
        ev_in = 0; cyc(6);
        chk(count_o == 2, "R6", count_o, 2, "falling edge ignored");
        for (int i = 0; i < 9; i++) pulse(1 + (i % 3), 2 + (i % 2));
        cyc(4);
        cnt_en = 0; ext_sel = 0; cyc(2);

        // R5 slowest ratio
        cur_req = "R5";
        clk_sel = 3'd7; cmp_val = 16'd1; cnt_en = 1;
        gap(n); chk(n == 256, "R5", n, 256, "period C=1 div128");

        cmp_on = 0;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule